// File: doc/BRIEF.md
# Synchronous burst address generator

This block produces the address stream for a pipelined synchronous memory. A start address is captured from the external address bus on any rising clock edge where either of two independent burst-start strobes is high. The captured address is presented on the next cycle with a first-beat flag. From then on the two lowest address bits are stepped internally, once for each cycle in which the advance input is high. The upper address bits never change inside a burst.

The order of the low bits is chosen by a mode input. In interleaved order the low bits are the starting low bits XOR the beat count. In linear order they are the starting low bits plus the beat count, modulo four. Either way the low bits wrap within the aligned four-beat block. Bursts are optional: a fresh address can be captured on every cycle, and each capture restarts the burst at beat zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the next cycle shows `mem_addr` = 0 and `first_beat` = 0. After reset the generator is idle.
- R2: A rising edge with `strobe_a` = 1 captures `ext_addr`. In the next cycle `mem_addr` equals that address and `first_beat` = 1.
- R3: A rising edge with `strobe_b` = 1 captures `ext_addr` exactly as `strobe_a` does.
- R4: When both strobes are high at the same edge, a single capture takes place, with the same result as one strobe.
- R5: An edge with `advance` = 1, both strobes low and a burst active moves the burst to its next beat. The next cycle shows `first_beat` = 0.
- R6: With `interleave` = 1 (interleaved order, which is also the level a pulled-up unconnected mode input gives), `mem_addr[1:0]` equals start[1:0] XOR beat, where beat counts advances since the capture, modulo 4.
- R7: With `interleave` = 0 (linear order), `mem_addr[1:0]` equals (start[1:0] + beat) mod 4.
- R8: `mem_addr[ADDR_W-1:2]` stays equal to the captured address for the whole burst. After four advances the low bits are back at the start value.
- R9: An edge with no strobe and `advance` = 0 leaves `mem_addr` and `first_beat` unchanged.
- R10: `advance` = 1 with no burst active has no effect. After reset, `mem_addr` stays 0.
- R11: When a strobe and `advance` are both high at one edge, the capture wins. The next cycle shows the new address with `first_beat` = 1.
- R12: Reset in the middle of a burst ends it. Afterwards `mem_addr` = 0, and `advance` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_a | input | 1 | First burst-start strobe |
| strobe_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat of the active burst |
| interleave | input | 1 | Order select: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External start address |
| mem_addr | output | ADDR_W | Current memory address |
| first_beat | output | 1 | High for the first beat of a burst |

## Verification
Every control input is registered exactly once. The result of a strobe, advance or reset sampled at one rising edge therefore appears on `mem_addr` and `first_beat` in the cycle after that edge. The order select acts combinationally on the registered beat count. The driver applies inputs at the falling edge and queues the expected result for the coming rising edge. The monitor takes one entry per rising edge and compares it a short delay after the edge, so every value is checked exactly one register stage after its stimulus.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned BURST_BITS = 2;
  localparam int unsigned BURST_LEN  = 1 << BURST_BITS;

  typedef logic [BURST_BITS-1:0] beat_t;

  function automatic beat_t lin_lo(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  function automatic beat_t ilv_lo(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction
endpackage

// File: rtl/bag_strobe_ctl.sv
module bag_strobe_ctl (
  input  logic strobe_a,
  input  logic strobe_b,
  input  logic advance,
  input  logic active,
  output logic load_ev,
  output logic step_ev
);
  always_comb begin
    load_ev = strobe_a | strobe_b;
    step_ev = advance & active & ~load_ev;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
  import bag_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_ev,
  input  logic  step_ev,
  output beat_t beat,
  output logic  active,
  output logic  first
);
  always_ff @(posedge clk) begin
    if (rst) begin
      beat   <= '0;
      active <= 1'b0;
      first  <= 1'b0;
    end else if (load_ev) begin
      beat   <= '0;
      active <= 1'b1;
      first  <= 1'b1;
    end else if (step_ev) begin
      beat   <= beat_t'(beat + 1'b1);
      first  <= 1'b0;
    end
  end

  // R9: without a capture or a step, the beat and the flag hold
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load_ev && !step_ev) |=> ($stable(beat) && $stable(first)));

  // R5: a step clears the first-beat flag
  p_first_clear_r5: assert property (@(posedge clk) disable iff (rst)
    step_ev |=> !first);

  // R10: while idle, the count does not move
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !load_ev) |=> (!active && beat == '0));
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ev,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)          base <= '0;
    else if (load_ev) base <= ext_addr;
  end

  // R8: the start address is held for the whole burst
  p_base_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> $stable(base));
endmodule

// File: rtl/bag_addr_out.sv
module bag_addr_out
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              interleave,
  input  logic [ADDR_W-1:0] base,
  input  beat_t             beat,
  output logic [ADDR_W-1:0] mem_addr
);
  beat_t start_lo;
  beat_t cur_lo;

  always_comb begin
    start_lo = base[BURST_BITS-1:0];
    cur_lo   = interleave ? ilv_lo(start_lo, beat) : lin_lo(start_lo, beat);
    mem_addr = {base[ADDR_W-1:BURST_BITS], cur_lo};
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              first_beat
);
  logic              load_ev;
  logic              step_ev;
  logic              active;
  beat_t             beat;
  logic [ADDR_W-1:0] base;

  bag_strobe_ctl u_ctl (
    .strobe_a (strobe_a),
    .strobe_b (strobe_b),
    .advance  (advance),
    .active   (active),
    .load_ev  (load_ev),
    .step_ev  (step_ev)
  );

  bag_beat_ctr u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load_ev (load_ev),
    .step_ev (step_ev),
    .beat    (beat),
    .active  (active),
    .first   (first_beat)
  );

  bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .load_ev  (load_ev),
    .ext_addr (ext_addr),
    .base     (base)
  );

  bag_addr_out #(.ADDR_W(ADDR_W)) u_out (
    .interleave (interleave),
    .base       (base),
    .beat       (beat),
    .mem_addr   (mem_addr)
  );

  // R1: reset leaves the outputs at zero
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !first_beat));

  // R2: a capture presents the sampled address as the first beat
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe_a || strobe_b) |=> (first_beat && mem_addr == $past(ext_addr)));

  // R11: a strobe outranks advance at the same edge
  p_priority_r11: assert property (@(posedge clk) disable iff (rst)
    ((strobe_a || strobe_b) && advance) |=> first_beat);

  // R8: the upper bits do not move inside a burst
  p_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !strobe_b && $stable(interleave))
      |=> $stable(mem_addr[ADDR_W-1:BURST_BITS]));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic          strobe_a, strobe_b, advance, interleave;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] mem_addr;
  logic          first_beat;

  typedef struct {
    logic [AW-1:0] addr;
    logic          first;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  bit            m_act = 1'b0;
  bit            m_first = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .advance(advance), .interleave(interleave), .ext_addr(ext_addr),
    .mem_addr(mem_addr), .first_beat(first_beat)
  );

  function automatic logic [AW-1:0] model_addr(bit ilv);
    int s;
    int lo;
    s = int'(m_base[1:0]);
    if (ilv) begin
      lo = 0;
      if ((s & 1) != (m_beat & 1)) lo = lo + 1;
      if ((s & 2) != (m_beat & 2)) lo = lo + 2;
    end else begin
      lo = s + m_beat;
      if (lo >= 4) lo = lo - 4;
    end
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic step(bit r, bit sa, bit sb, bit adv, bit ilv,
                      logic [AW-1:0] a, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; strobe_a = sa; strobe_b = sb; advance = adv;
    interleave = ilv; ext_addr = a;
    if (r) begin
      m_base = '0; m_beat = 0; m_act = 0; m_first = 0;
    end else if (sa || sb) begin
      m_base = a; m_beat = 0; m_act = 1; m_first = 1;
    end else if (adv && m_act) begin
      m_beat = (m_beat + 1) % 4; m_first = 0;
    end
    e.addr = model_addr(ilv);
    e.first = m_first;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (mem_addr !== e.addr || first_beat !== e.first) begin
          failures++;
          $display("FAIL %s: addr=%h first=%b expected addr=%h first=%b",
                   e.tag, mem_addr, first_beat, e.addr, e.first);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    rst = 1; strobe_a = 0; strobe_b = 0; advance = 0;
    interleave = 1; ext_addr = '0;
    step(1, 0, 0, 0, 1, '0, "R1");
    step(1, 0, 0, 1, 1, 18'h3FFFF, "R1");
    // R10: advance with no burst
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 18'h00005, "R10");
    // R2 and R6: interleaved burst from low bits 01
    step(0, 1, 0, 0, 1, 18'h12345, "R2");
    step(0, 0, 0, 1, 1, '0, "R6");
    step(0, 0, 0, 0, 1, '0, "R9");
    step(0, 0, 0, 0, 1, '0, "R9");
    step(0, 0, 0, 1, 1, '0, "R6");
    step(0, 0, 0, 1, 1, '0, "R6");
    step(0, 0, 0, 1, 1, '0, "R8");
    step(0, 0, 0, 1, 1, '0, "R8");
    // R3 and R11: strobe_b together with advance, then linear order
    step(0, 0, 1, 1, 0, 18'h0ABC6, "R11");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, '0, "R7");
    step(0, 0, 0, 1, 0, '0, "R8");
    step(0, 0, 1, 0, 0, 18'h00A53, "R3");
    step(0, 0, 0, 1, 0, '0, "R7");
    // R4: both strobes at once
    step(0, 1, 1, 0, 1, 18'h3FFFE, "R4");
    step(0, 0, 0, 1, 1, '0, "R4");
    step(0, 0, 0, 1, 1, '0, "R6");
    // R2: back-to-back captures
    step(0, 1, 0, 1, 0, 18'h00011, "R2");
    step(0, 1, 0, 0, 0, 18'h2222F, "R2");
    step(0, 0, 0, 1, 0, '0, "R7");
    // R12: reset mid-burst
    step(1, 0, 0, 1, 0, 18'h11111, "R12");
    step(0, 0, 0, 1, 0, '0, "R12");
    step(0, 0, 0, 1, 1, '0, "R12");
    @(negedge clk);
    strobe_a = 0; strobe_b = 0; advance = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule